// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models, on the device side, the status word a parallel NOR flash returns while an embedded program or erase runs. A sequencer outside the block reports the current operation mode (idle, programming, erasing, erase-suspended) and signals the moment its command sequence has completed. From that moment the block is armed. Every read strobe then returns a status byte instead of array data.

The status byte carries two toggle bits and a failure flag. The operation toggle (bit 6) inverts on every read while an operation runs, whatever the address. The sector toggle (bit 2) inverts only on reads whose address lies in a sector marked for erase. Reading both bits tells the host whether erase is running or suspended, and which sectors are selected. An internal counter advances once per clock while an armed operation is active. If the operation stays active for `PULSE_LIMIT` clocks, the failure flag (bit 5) rises. The block then stays busy until a reset command arrives. The reset command also reports whether the device should go back to erase-suspend-read instead of plain read mode.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `dout_o` is 0, `back_susp_o` is 0, both toggle bits hold 0, and `ready_o` is 1 while `mode_i` is idle.
- R2: When the block is not armed, a read strobe loads `array_data_i` into `dout_o` and leaves both toggle bits unchanged. The block is not armed after reset, after a reset command, or once `mode_i` is idle without a failure.
- R3: While armed and `mode_i` is program (1) or erase (2), every read strobe inverts the operation toggle on `dout_o[6]`, at any address.
- R4: While armed and `mode_i` is erase-suspended (3) with no failure, reads leave the operation toggle unchanged.
- R5: While armed and `mode_i` is erase or erase-suspended, a read inverts the sector toggle on `dout_o[2]` when bit s of `erase_sel_i` is set. Here s is `rd_addr_i >> SECT_LSB`.
- R6: The sector toggle holds on reads of unselected sectors and on any read while programming.
- R7: The failure flag `dout_o[5]` becomes 1 on the first read sampled after `PULSE_LIMIT` clock edges of armed activity, counted from the edge after `cmd_done_i`. An operation that returns to idle earlier reports no failure.
- R8: `ready_o` is 0 while `mode_i` is program or erase, and while a failure is held. It is 1 otherwise, including during erase suspend.
- R9: A reset command clears the failure and disarms the block, so the next read returns array data. On the same edge, `back_susp_o` takes the value of `susp_prog_i`.
- R10: `dout_o` changes only on the clock edge where `rd_strobe_i` is high. A status byte has all bits other than 6, 5 and 2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 idle, 1 program, 2 erase, 3 erase-suspended |
| cmd_done_i | input | 1 | One-cycle pulse: final write of the command sequence; arms the block and restarts the counter |
| rd_strobe_i | input | 1 | One-cycle pulse per host read cycle |
| rd_addr_i | input | ADDR_W | Read address; sector index is `rd_addr_i >> SECT_LSB` |
| erase_sel_i | input | NUM_SECTORS | Per-sector erase-selected mask |
| reset_cmd_i | input | 1 | Reset command pulse |
| susp_prog_i | input | 1 | The bank was in erase-suspend-program when the reset command arrives |
| array_data_i | input | DATA_W | Array data returned on reads outside status mode |
| dout_o | output | DATA_W | Registered read data or status byte |
| ready_o | output | 1 | 1 ready, 0 busy |
| back_susp_o | output | 1 | After a reset command: go back to erase-suspend-read |

## Verification
Each read result is due one edge after its strobe. The bench raises the strobe just after an edge, lets one edge pass, and samples `dout_o` before the following edge. `ready_o` follows `mode_i` and the failure flag in the same cycle, so it is checked right after the inputs settle. The failure flag is checked at two reads: one at exactly `PULSE_LIMIT` edges after the arming edge, where 0 is expected, and one at the edge after that, where 1 is expected. The bench tracks both toggle bits in its own model, sector by sector, across every phase.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_SUSP  = 2'd3
    } op_mode_e;

    localparam int STAT_TGL_OP   = 6;
    localparam int STAT_FAIL     = 5;
    localparam int STAT_TGL_SECT = 2;
endpackage

// File: rtl/fsg_sector_match.sv
module fsg_sector_match #(
    parameter int ADDR_W      = 12,
    parameter int NUM_SECTORS = 8,
    parameter int SECT_LSB    = 9
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [NUM_SECTORS-1:0] sel_i,
    output logic                   hit_o
);
    logic [ADDR_W-1:0]      sect_idx;
    logic [NUM_SECTORS-1:0] hit_vec;

    assign sect_idx = addr_i >> SECT_LSB;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sect
        assign hit_vec[i] = (sect_idx == ADDR_W'(i)) && sel_i[i];
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/fsg_pulse_timer.sv
module fsg_pulse_timer #(
    parameter int PULSE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic clear_i,
    output logic fail_o
);
    localparam int CNT_W = $clog2(PULSE_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fail;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt  = '0;
            st_d.fail = 1'b0;
        end else if (restart_i) begin
            st_d.cnt = '0;
        end else if (run_i && !st_q.fail) begin
            if (st_q.cnt == CNT_W'(PULSE_LIMIT - 1)) begin
                st_d.fail = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fail_o = st_q.fail;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_SECTORS = 8,
    parameter int SECT_LSB    = 9,
    parameter int DATA_W      = 8,
    parameter int PULSE_LIMIT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode_i,
    input  logic                   cmd_done_i,
    input  logic                   rd_strobe_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    input  logic [NUM_SECTORS-1:0] erase_sel_i,
    input  logic                   reset_cmd_i,
    input  logic                   susp_prog_i,
    input  logic [DATA_W-1:0]      array_data_i,
    output logic [DATA_W-1:0]      dout_o,
    output logic                   ready_o,
    output logic                   back_susp_o
);
    typedef struct packed {
        logic              tgl_op;
        logic              tgl_sect;
        logic              armed;
        logic              back_susp;
        logic [DATA_W-1:0] dout;
    } state_t;

    state_t   st_d, st_q;
    op_mode_e mode;
    logic     active;
    logic     erase_ctx;
    logic     sect_hit;
    logic     fail_w;
    logic     show_stat;

    assign mode      = op_mode_e'(mode_i);
    assign active    = (mode == MODE_PROG) || (mode == MODE_ERASE);
    assign erase_ctx = (mode == MODE_ERASE) || (mode == MODE_SUSP);

    fsg_sector_match #(
        .ADDR_W     (ADDR_W),
        .NUM_SECTORS(NUM_SECTORS),
        .SECT_LSB   (SECT_LSB)
    ) u_match (
        .addr_i(rd_addr_i),
        .sel_i (erase_sel_i),
        .hit_o (sect_hit)
    );

    fsg_pulse_timer #(
        .PULSE_LIMIT(PULSE_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.armed && active),
        .restart_i(cmd_done_i && !reset_cmd_i),
        .clear_i  (reset_cmd_i),
        .fail_o   (fail_w)
    );

    assign show_stat = st_q.armed && ((mode != MODE_IDLE) || fail_w);

    always_comb begin
        st_d = st_q;

        if (reset_cmd_i) begin
            st_d.armed = 1'b0;
        end else if (cmd_done_i) begin
            st_d.armed = 1'b1;
        end else if ((mode == MODE_IDLE) && !fail_w) begin
            st_d.armed = 1'b0;
        end

        if (reset_cmd_i) begin
            st_d.back_susp = susp_prog_i;
        end else if (cmd_done_i) begin
            st_d.back_susp = 1'b0;
        end

        if (rd_strobe_i) begin
            if (show_stat) begin
                if (active || fail_w) begin
                    st_d.tgl_op = !st_q.tgl_op;
                end
                if (erase_ctx && sect_hit) begin
                    st_d.tgl_sect = !st_q.tgl_sect;
                end
                st_d.dout                = '0;
                st_d.dout[STAT_TGL_OP]   = st_d.tgl_op;
                st_d.dout[STAT_FAIL]     = fail_w;
                st_d.dout[STAT_TGL_SECT] = st_d.tgl_sect;
            end else begin
                st_d.dout = array_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o      = st_q.dout;
    assign back_susp_o = st_q.back_susp;
    assign ready_o     = !(active || fail_w);
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe_i,
    input logic              reset_cmd_i,
    input logic              susp_prog_i,
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] array_data_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              back_susp_o,
    input logic              armed,
    input logic              tgl_op,
    input logic              fail_w
);
    assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> $stable(dout_o));

    assert_unarmed_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && !armed) |=> (dout_o == $past(array_data_i)));

    assert_susp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && !fail_w) |=> $stable(tgl_op));

    assert_fail_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd_i |=> !fail_w);

    assert_back_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd_i |=> (back_susp_o == $past(susp_prog_i)));

    assert_fail_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_w) |-> ($past(armed) && ($past(mode_i) == 2'd1 || $past(mode_i) == 2'd2)));
endmodule

bind flash_status_gen fsg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe_i (rd_strobe_i),
    .reset_cmd_i (reset_cmd_i),
    .susp_prog_i (susp_prog_i),
    .mode_i      (mode_i),
    .array_data_i(array_data_i),
    .dout_o      (dout_o),
    .back_susp_o (back_susp_o),
    .armed       (st_q.armed),
    .tgl_op      (st_q.tgl_op),
    .fail_w      (fail_w)
);

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int NSECT      = 8;
    localparam int SLSB       = 9;
    localparam int DW         = 8;
    localparam int LIMIT      = 200;
    localparam logic [NSECT-1:0] SEL = 8'b1010_0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic cmd_done = 1'b0, rd = 1'b0, rcmd = 1'b0, sprog = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [NSECT-1:0] sel = SEL;
    logic [DW-1:0] adata = '0;
    logic [DW-1:0] dout;
    logic ready, bsusp;

    int checks = 0, fails = 0;
    logic e6 = 1'b0, e2 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_gen #(
        .ADDR_W(ADDR_W), .NUM_SECTORS(NSECT), .SECT_LSB(SLSB),
        .DATA_W(DW), .PULSE_LIMIT(LIMIT)
    ) u_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmd_done_i(cmd_done),
        .rd_strobe_i(rd), .rd_addr_i(addr), .erase_sel_i(sel),
        .reset_cmd_i(rcmd), .susp_prog_i(sprog), .array_data_i(adata),
        .dout_o(dout), .ready_o(ready), .back_susp_o(bsusp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] stat(input logic t6, input logic f, input logic t2);
        logic [DW-1:0] v;
        v = '0;
        v[6] = t6;
        v[5] = f;
        v[2] = t2;
        return v;
    endfunction

    task automatic do_read(input int s, input logic [DW-1:0] d);
        addr  = ADDR_W'((s << SLSB) | ((s * 37) & 9'h1ff));
        adata = d;
        rd    = 1'b1;
        tick();
        rd    = 1'b0;
    endtask

    task automatic arm(input logic [1:0] m);
        mode = m;
        cmd_done = 1'b1;
        tick();
        cmd_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 250000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick();
        chk("R1 dout after reset", dout, 0);
        chk("R1 ready after reset", ready, 1);
        chk("R1 back_susp after reset", bsusp, 0);
        rst_n = 1'b1;
        tick();

        // R2 / R10: unarmed reads in idle and in erase return array data
        for (int i = 0; i < 4; i++) begin
            do_read(i, DW'(8'h3c + i * 17));
            chk("R2 idle array read", dout, DW'(8'h3c + i * 17));
        end
        mode = 2'd2;
        #1;
        chk("R8 busy while erasing", ready, 0);
        do_read(0, 8'hc3);
        chk("R2 unarmed erase read", dout, 8'hc3);
        tick();
        chk("R10 dout holds without strobe", dout, 8'hc3);

        // erase: sweep every sector twice
        arm(2'd2);
        for (int s = 0; s < NSECT; s++) begin
            for (int k = 0; k < 2; k++) begin
                do_read(s, 8'hff);
                e6 = ~e6;
                if (SEL[s]) e2 = ~e2;
                chk("R3 R5 R6 erase status", dout, stat(e6, 1'b0, e2));
            end
        end

        // suspend: operation toggle holds, sector toggle follows selection
        mode = 2'd3;
        #1;
        chk("R8 ready in suspend", ready, 1);
        for (int s = 0; s < NSECT; s++) begin
            do_read(s, 8'h00);
            if (SEL[s]) e2 = ~e2;
            chk("R4 R5 suspend status", dout, stat(e6, 1'b0, e2));
        end

        // go idle (disarm), then program
        mode = 2'd0;
        tick();
        do_read(2, 8'h5a);
        chk("R2 idle disarms", dout, 8'h5a);
        arm(2'd1);
        chk("R8 busy while programming", ready, 0);
        for (int s = 0; s < NSECT; s++) begin
            do_read(s, 8'hff);
            e6 = ~e6;
            chk("R3 R6 program status", dout, stat(e6, 1'b0, e2));
        end
        mode = 2'd0;
        tick();
        do_read(1, 8'h81);
        chk("R7 early finish no failure", dout, 8'h81);
        chk("R7 early finish ready", ready, 1);

        // timeout: arming edge E0, failure after edge E0+LIMIT
        arm(2'd1);
        for (int i = 0; i < LIMIT - 1; i++) tick();
        do_read(3, 8'h00);
        e6 = ~e6;
        chk("R7 no failure at limit edge", dout, stat(e6, 1'b0, e2));
        do_read(3, 8'h00);
        e6 = ~e6;
        chk("R7 failure after limit", dout, stat(e6, 1'b1, e2));
        mode = 2'd0;
        #1;
        chk("R8 busy while failed", ready, 0);
        do_read(4, 8'h00);
        e6 = ~e6;
        chk("R7 failure held in idle", dout, stat(e6, 1'b1, e2));

        // reset command back to erase-suspend-read
        sprog = 1'b1;
        rcmd  = 1'b1;
        tick();
        rcmd  = 1'b0;
        chk("R9 back_susp set", bsusp, 1);
        chk("R9 ready after reset cmd", ready, 1);
        do_read(5, 8'h96);
        chk("R9 array data after reset cmd", dout, 8'h96);
        sprog = 1'b0;
        rcmd  = 1'b1;
        tick();
        rcmd  = 1'b0;
        chk("R9 back_susp cleared", bsusp, 0);

        // re-arm erase to confirm toggle state persisted
        arm(2'd2);
        do_read(0, 8'h00);
        e6 = ~e6;
        e2 = ~e2;
        chk("R3 R5 toggles continue", dout, stat(e6, 1'b0, e2));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule